// File: doc/BRIEF.md
# Flat Unified Memory Address Router

This block sits between a processor core and three single-port memories that share one flat 20-bit byte-address space. The lowest 512 bytes hold a core-local register RAM. The next 512 bytes hold an extended core-local RAM. Every address above that reaches a large shared RAM. Several cores use the shared RAM in round-robin time slots, and a slot-valid input tells this core when its slot is open.

The core raises `req_valid` with a write flag, a size (byte, word or long) and an address. It keeps all request fields steady until it sees `rsp_ready` or `rsp_err`. The router decodes the region and checks size and alignment. It then drives one memory enable with a long index that is relative to the start of that region, spreads the write data across the byte lanes, and returns zero-extended read data.

Each memory returns read data one cycle after its enable. The shared RAM writes whole longs only. A byte or word write to the shared RAM is therefore done as a read in one slot followed by a merged write in a later slot.

Top module: `flat_mem_router`

## Requirements
- R1: Byte addresses 0x000–0x1FF assert `loc_en`, 0x200–0x3FF assert `ext_en`, and 0x400 upward assert `shr_en`. In every case `mem_idx` equals (address − region base) / 4.
- R2: A valid access to either core-local region drives its enable in the cycle the request is taken, and `rsp_ready` is high in the following cycle, with no dependence on `slot_valid`.
- R3: A request with size code 3, a word (size 1) with address bit 0 set, or a long (size 2) with address bits 1:0 non-zero raises `rsp_err` for one cycle in the cycle after the request is taken. It drives no memory enable, so memory contents stay unchanged.
- R4: In the extended region, any size other than long (size 2) is rejected exactly as in R3, and no write occurs.
- R5: `shr_en` is asserted only in cycles where `slot_valid` is high. `rsp_ready` stays low while the router waits for a slot, and it rises in the cycle after the issuing slot.
- R6: A byte or word write to the shared RAM uses two slots: first a read, then a full-long write that merges the new lanes into the old long. Every shared write carries `mem_be` = 4'hF.
- R7: Size codes are 0 = byte, 1 = word, 2 = long. Write data is the low byte repeated four times, or the low half-word repeated twice, or the full long. Byte enables are 1 << addr[1:0] for a byte, 3 << addr[1:0] for a word, and 4'hF for a long. Read data is the addressed lanes, shifted down and zero-extended.
- R8: At most one memory enable is high in any cycle. `rsp_ready` and `rsp_err` are one-cycle pulses and are never high together.
- R9: During and right after reset, no enable, `rsp_ready` or `rsp_err` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until ready or error |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 reserved |
| req_addr | input | 20 | Flat byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| slot_valid | input | 1 | This core's shared-RAM slot is open |
| rsp_ready | output | 1 | Access done pulse |
| rsp_err | output | 1 | Rejected access pulse |
| rsp_rdata | output | 32 | Zero-extended read data, valid with rsp_ready |
| loc_en | output | 1 | Register RAM enable |
| ext_en | output | 1 | Extended RAM enable |
| shr_en | output | 1 | Shared RAM enable |
| mem_we | output | 1 | Write strobe for the enabled memory |
| mem_idx | output | 18 | Long index within the selected region |
| mem_wdata | output | 32 | Lane-spread or merged write data |
| mem_be | output | 4 | Byte enables |
| loc_rdata | input | 32 | Register RAM read data, one cycle after enable |
| ext_rdata | input | 32 | Extended RAM read data |
| shr_rdata | input | 32 | Shared RAM read data |

## Verification
The assertions check the following on every cycle: only one memory enable is high at a time; the shared enable appears only inside a slot; every shared or extended write is a full long; a ready pulse always follows an issued access; and an error pulse never follows an issue. Only the bench scenarios can show the rest. That covers correct region bases and indices, exact lane contents of reads, whether a two-slot merged write keeps the untouched bytes, and whether a rejected access really left memory intact. The bench shows these by reading back through a shadow image.

// File: rtl/fmr_pkg.sv
package fmr_pkg;

  typedef enum logic [1:0] {RG_LOC = 2'd0, RG_EXT = 2'd1, RG_SHR = 2'd2} region_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SWAIT, ST_CAP, ST_RMWW, ST_RESP, ST_ERR
  } state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  // byte enables for a given size at a given byte offset
  function automatic logic [3:0] lane_mask(logic [1:0] sz, logic [1:0] off);
    case (sz)
      SZ_BYTE: return 4'b0001 << off;
      SZ_WORD: return 4'b0011 << {off[1], 1'b0};
      default: return 4'hF;
    endcase
  endfunction

  // copy right-aligned write data onto every lane of its size
  function automatic logic [31:0] spread(logic [1:0] sz, logic [31:0] d);
    case (sz)
      SZ_BYTE: return {4{d[7:0]}};
      SZ_WORD: return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  // shift the addressed lanes down and zero-extend
  function automatic logic [31:0] pick(logic [1:0] sz, logic [1:0] off, logic [31:0] r);
    logic [31:0] s;
    s = r >> {off, 3'b000};
    case (sz)
      SZ_BYTE: return {24'd0, s[7:0]};
      SZ_WORD: return {16'd0, s[15:0]};
      default: return r;
    endcase
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
    logic [31:0] o;
    for (int i = 0; i < 4; i++) o[8*i +: 8] = m[i] ? nw[8*i +: 8] : old[8*i +: 8];
    return o;
  endfunction

endpackage

// File: rtl/fmr_decode.sv
module fmr_decode
  import fmr_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int LOC_BYTES = 512,
  parameter int EXT_BYTES = 512
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output region_e           region,
  output logic [ADDR_W-3:0] idx,
  output logic              sub_long,
  output logic              dec_err
);
  localparam logic [ADDR_W-1:0] EXT_LO = ADDR_W'(LOC_BYTES);
  localparam logic [ADDR_W-1:0] SHR_LO = ADDR_W'(LOC_BYTES + EXT_BYTES);

  logic [ADDR_W-1:0] base;
  logic bad_align, bad_ext;

  function automatic logic [ADDR_W-3:0] rebase(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] lo);
    return a[ADDR_W-1:2] - lo[ADDR_W-1:2];
  endfunction

  always_comb begin
    if (addr < EXT_LO) begin
      region = RG_LOC;
      base   = '0;
    end else if (addr < SHR_LO) begin
      region = RG_EXT;
      base   = EXT_LO;
    end else begin
      region = RG_SHR;
      base   = SHR_LO;
    end
    idx       = rebase(addr, base);
    sub_long  = (size != SZ_LONG);
    bad_align = (size == 2'd3) || (size == SZ_WORD && addr[0]) ||
                (size == SZ_LONG && addr[1:0] != 2'b00);
    bad_ext   = (region == RG_EXT) && (size != SZ_LONG);
    dec_err   = bad_align || bad_ext;
  end
endmodule

// File: rtl/fmr_lanes.sv
module fmr_lanes
  import fmr_pkg::*;
(
  input  logic [1:0]  wr_size,
  input  logic [1:0]  wr_off,
  input  logic [31:0] wr_data,
  input  logic [31:0] old_long,
  input  logic [1:0]  rd_size,
  input  logic [1:0]  rd_off,
  input  logic [31:0] rd_raw,
  output logic [31:0] wr_spread,
  output logic [3:0]  wr_mask,
  output logic [31:0] wr_merged,
  output logic [31:0] rd_val
);
  always_comb begin
    wr_spread = spread(wr_size, wr_data);
    wr_mask   = lane_mask(wr_size, wr_off);
    wr_merged = merge(old_long, wr_spread, wr_mask);
    rd_val    = pick(rd_size, rd_off, rd_raw);
  end
endmodule

// File: rtl/fmr_ctrl.sv
module fmr_ctrl
  import fmr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_write,
  input  region_e region,
  input  logic    sub_long,
  input  logic    dec_err,
  input  logic    slot_valid,
  output logic    go_prim,
  output logic    rmw_read,
  output logic    go_rmw,
  output logic    cap_en,
  output logic    rsp_ready,
  output logic    rsp_err
);
  state_e st, nxt;
  logic idle_req, ev_wait;

  always_comb begin
    idle_req = (st == ST_IDLE) && req_valid;
    ev_wait  = (st == ST_SWAIT) || (st == ST_RMWW);
    go_prim  = (idle_req && !dec_err && (region != RG_SHR || slot_valid)) ||
               (st == ST_SWAIT && slot_valid);
    rmw_read = go_prim && region == RG_SHR && req_write && sub_long;
    go_rmw   = (st == ST_RMWW) && slot_valid;
    cap_en   = (st == ST_CAP);
    rsp_ready = (st == ST_RESP);
    rsp_err   = (st == ST_ERR);

    nxt = st;
    case (st)
      ST_IDLE:  if (req_valid) begin
                  if (dec_err)      nxt = ST_ERR;
                  else if (go_prim) nxt = rmw_read ? ST_CAP : ST_RESP;
                  else              nxt = ST_SWAIT;
                end
      ST_SWAIT: if (slot_valid) nxt = rmw_read ? ST_CAP : ST_RESP;
      ST_CAP:   nxt = ST_RMWW;
      ST_RMWW:  if (slot_valid) nxt = ST_RESP;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  // R5: no response while waiting for a slot
  a_r5_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wait && !slot_valid) |=> !rsp_ready && !rsp_err);
  // R3: a rejected request is never issued to memory
  a_r3_err_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && dec_err) |-> !go_prim && !go_rmw);
endmodule

// File: rtl/flat_mem_router.sv
module flat_mem_router
  import fmr_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int LOC_BYTES = 512,
  parameter int EXT_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              slot_valid,
  output logic              rsp_ready,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              loc_en,
  output logic              ext_en,
  output logic              shr_en,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_idx,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       loc_rdata,
  input  logic [31:0]       ext_rdata,
  input  logic [31:0]       shr_rdata
);
  region_e     region, rg_q;
  logic        sub_long, dec_err;
  logic        go_prim, rmw_read, go_rmw, cap_en;
  logic [1:0]  sz_q, off_q;
  logic [31:0] old_q, raw_sel;
  logic [31:0] wr_spread, wr_merged;
  logic [3:0]  wr_mask;
  logic        ev_issue;

  fmr_decode #(.ADDR_W(ADDR_W), .LOC_BYTES(LOC_BYTES), .EXT_BYTES(EXT_BYTES)) u_dec (
    .addr(req_addr), .size(req_size), .region(region), .idx(mem_idx),
    .sub_long(sub_long), .dec_err(dec_err));

  fmr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .region(region), .sub_long(sub_long), .dec_err(dec_err), .slot_valid(slot_valid),
    .go_prim(go_prim), .rmw_read(rmw_read), .go_rmw(go_rmw), .cap_en(cap_en),
    .rsp_ready(rsp_ready), .rsp_err(rsp_err));

  fmr_lanes u_lanes (
    .wr_size(req_size), .wr_off(req_addr[1:0]), .wr_data(req_wdata), .old_long(old_q),
    .rd_size(sz_q), .rd_off(off_q), .rd_raw(raw_sel),
    .wr_spread(wr_spread), .wr_mask(wr_mask), .wr_merged(wr_merged), .rd_val(rsp_rdata));

  always_comb begin
    loc_en    = go_prim && region == RG_LOC;
    ext_en    = go_prim && region == RG_EXT;
    shr_en    = (go_prim && region == RG_SHR) || go_rmw;
    ev_issue  = loc_en || ext_en || shr_en;
    mem_we    = (go_prim && req_write && !rmw_read) || go_rmw;
    mem_wdata = go_rmw ? wr_merged : wr_spread;
    mem_be    = go_rmw ? 4'hF : wr_mask;
    case (rg_q)
      RG_LOC:  raw_sel = loc_rdata;
      RG_EXT:  raw_sel = ext_rdata;
      default: raw_sel = shr_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rg_q  <= RG_LOC;
      sz_q  <= SZ_LONG;
      off_q <= 2'b00;
      old_q <= '0;
    end else begin
      if (go_prim) begin
        rg_q  <= region;
        sz_q  <= req_size;
        off_q <= req_addr[1:0];
      end
      if (cap_en) old_q <= shr_rdata;
    end
  end

  // R8: one memory per cycle, exclusive pulses
  a_r8_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loc_en, ext_en, shr_en}));
  a_r8_excl_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ready && rsp_err));
  // R5: shared RAM touched only inside a slot
  a_r5_slot_gate: assert property (@(posedge clk) disable iff (!rst_n)
    shr_en |-> slot_valid);
  // R2/R5: a ready pulse always follows an issue
  a_r2_ready_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> $past(ev_issue));
  // R3: an error pulse never follows an issue
  a_r3_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !$past(ev_issue));
  // R4: extended region sees only full longs
  a_r4_ext_long: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en |-> mem_be == 4'hF);
  // R6: shared writes are whole longs
  a_r6_shared_full: assert property (@(posedge clk) disable iff (!rst_n)
    (shr_en && mem_we) |-> mem_be == 4'hF);
  // R9: quiet right after reset
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !rsp_ready && !rsp_err);
endmodule

// File: tb/flat_mem_router_bench.sv
module flat_mem_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd2;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        slot_valid = 1'b0;
  logic        rsp_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic        loc_en, ext_en, shr_en, mem_we;
  logic [17:0] mem_idx;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] loc_rdata = '0, ext_rdata = '0, shr_rdata = '0;

  logic [31:0] loc_mem [128], ext_mem [128], shr_mem [256];
  logic [31:0] loc_sh  [128], ext_sh  [128], shr_sh  [256];

  int checks = 0, fails = 0;
  int mon_seen = 0, mon_rg = 0, mon_idx = 0, slots = 0, slot_cnt = 0;

  always #5 clk = ~clk;

  flat_mem_router u_flat_mem_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .slot_valid(slot_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .loc_en(loc_en), .ext_en(ext_en), .shr_en(shr_en),
    .mem_we(mem_we), .mem_idx(mem_idx), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .loc_rdata(loc_rdata), .ext_rdata(ext_rdata), .shr_rdata(shr_rdata));

  // memory models: local RAMs honour byte enables, shared RAM writes whole longs
  always @(posedge clk) begin
    if (loc_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) loc_mem[mem_idx[6:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else loc_rdata <= loc_mem[mem_idx[6:0]];
    end
    if (ext_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) ext_mem[mem_idx[6:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else ext_rdata <= ext_mem[mem_idx[6:0]];
    end
    if (shr_en) begin
      if (mem_we) shr_mem[mem_idx[7:0]] <= mem_wdata;
      else        shr_rdata <= shr_mem[mem_idx[7:0]];
    end
    if (mon_seen == 0 && (loc_en || ext_en || shr_en)) begin
      mon_seen = 1;
      mon_rg   = loc_en ? 0 : (ext_en ? 1 : 2);
      mon_idx  = int'(mem_idx);
    end
    if (req_valid && slot_valid) slots = slots + 1;
  end

  // slot every fifth cycle
  always @(negedge clk) begin
    if (!rst_n) slot_cnt = 0;
    else slot_cnt = (slot_cnt == 4) ? 0 : slot_cnt + 1;
    slot_valid = rst_n && (slot_cnt == 0);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_bad(input logic [1:0] sz, input logic [19:0] a);
    bit misal;
    misal = (sz == 2'd3) || (sz == 2'd1 && a[0] == 1'b1) || (sz == 2'd2 && a[1:0] != 2'd0);
    return misal || (a >= 20'h200 && a < 20'h400 && sz != 2'd2);
  endfunction

  function automatic int region_of(input logic [19:0] a);
    if (a < 20'h200) return 0;
    if (a < 20'h400) return 1;
    return 2;
  endfunction

  function automatic int index_of(input logic [19:0] a);
    int r;
    r = region_of(a);
    return (int'(a) - (r == 0 ? 0 : (r == 1 ? 'h200 : 'h400))) / 4;
  endfunction

  function automatic logic [31:0] shadow_get(input logic [19:0] a);
    int r, i;
    r = region_of(a); i = index_of(a);
    if (r == 0) return loc_sh[i];
    if (r == 1) return ext_sh[i];
    return shr_sh[i];
  endfunction

  task automatic shadow_put(input logic [19:0] a, input logic [31:0] v);
    int r, i;
    r = region_of(a); i = index_of(a);
    if (r == 0) loc_sh[i] = v;
    else if (r == 1) ext_sh[i] = v;
    else shr_sh[i] = v;
  endtask

  function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [19:0] a, input logic [31:0] w);
    int nb;
    logic [31:0] v;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1 ? 2 : 4);
    v = '0;
    for (int k = 0; k < nb; k++) v[8*k +: 8] = w[8*(int'(a[1:0]) + k) +: 8];
    return v;
  endfunction

  function automatic logic [31:0] exp_write(input logic [1:0] sz, input logic [19:0] a,
                                            input logic [31:0] old, input logic [31:0] d);
    int nb;
    logic [31:0] v;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1 ? 2 : 4);
    v = old;
    for (int k = 0; k < nb; k++) v[8*(int'(a[1:0]) + k) +: 8] = d[8*k +: 8];
    return v;
  endfunction

  task automatic access(input bit wr, input logic [1:0] sz, input logic [19:0] a, input logic [31:0] d);
    int cyc;
    bit bad;
    logic [31:0] old;
    bad = exp_bad(sz, a);
    old = shadow_get(a);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    mon_seen = 0; slots = 0; cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rsp_ready && rsp_err) chk(0, "R8 both pulses", 32'd1, 32'd0);
      if (rsp_ready || rsp_err || cyc > 60) break;
    end
    req_valid = 1'b0;
    chk(rsp_err == bad && (rsp_ready || rsp_err), "R3/R4 outcome", {31'd0, rsp_err}, {31'd0, bad});
    if (bad) begin
      chk(mon_seen == 0, "R3 no memory access", mon_seen, 0);
      chk(cyc == 1, "R3 error latency", cyc, 1);
    end else begin
      chk(mon_seen == 1 && mon_rg == region_of(a) && mon_idx == index_of(a), "R1 region/index",
          mon_rg * 32'h10000 + mon_idx, region_of(a) * 32'h10000 + index_of(a));
      if (region_of(a) != 2) chk(cyc == 1, "R2 local latency", cyc, 1);
      if (!wr) chk(rsp_rdata == exp_read(sz, a, old), "R7 read lanes", rsp_rdata, exp_read(sz, a, old));
      else shadow_put(a, exp_write(sz, a, old, d));
      if (wr && region_of(a) == 2 && sz != 2'd2) chk(slots >= 2, "R6 two slots", slots, 2);
    end
  endtask

  task automatic readback(input logic [19:0] a, input string req);
    logic [19:0] al;
    logic [31:0] e;
    al = {a[19:2], 2'b00};
    e = shadow_get(al);
    access(1'b0, 2'd2, al, 32'd0);
    chk(rsp_rdata == e, req, rsp_rdata, e);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      loc_mem[i] = 32'hA5000000 ^ (i * 32'h00010203); loc_sh[i] = loc_mem[i];
      ext_mem[i] = 32'h5A000000 ^ (i * 32'h00030507); ext_sh[i] = ext_mem[i];
    end
    for (int i = 0; i < 256; i++) begin
      shr_mem[i] = 32'h3C000000 ^ (i * 32'h00070B0D); shr_sh[i] = shr_mem[i];
    end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!rsp_ready && !rsp_err && !loc_en && !ext_en && !shr_en, "R9 reset state",
        {rsp_ready, rsp_err, loc_en, ext_en, shr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_ready && !rsp_err, "R9 after reset", {rsp_ready, rsp_err}, 32'd0);

    // region boundaries (R1)
    access(1'b0, 2'd2, 20'h001FC, 0);
    access(1'b0, 2'd2, 20'h00200, 0);
    access(1'b0, 2'd2, 20'h003FC, 0);
    access(1'b0, 2'd2, 20'h00400, 0);
    // rejects leave memory untouched (R3, R4)
    access(1'b1, 2'd0, 20'h00205, 32'h000000EE);
    readback(20'h00204, "R4 ext unchanged");
    access(1'b1, 2'd1, 20'h00403, 32'h0000BEEF);
    readback(20'h00400, "R3 shared unchanged");
    access(1'b1, 2'd3, 20'h00010, 32'h12345678);
    access(1'b1, 2'd2, 20'h00012, 32'h12345678);
    readback(20'h00010, "R3 local unchanged");
    // merged shared write and local lanes (R6, R7)
    access(1'b1, 2'd0, 20'h00409, 32'h000000C3);
    readback(20'h00408, "R6 merge");
    access(1'b1, 2'd1, 20'h0040E, 32'h00009A7B);
    readback(20'h0040C, "R6 merge word");
    access(1'b1, 2'd1, 20'h0000E, 32'h0000F00D);
    readback(20'h0000C, "R7 local word");
    access(1'b0, 2'd0, 20'h0000F, 0);

    for (int n = 0; n < 400; n++) begin
      int r;
      logic [19:0] a;
      r = $urandom % 3;
      if (r == 0) a = 20'($urandom % 'h200);
      else if (r == 1) a = 20'('h200 + $urandom % 'h200);
      else a = 20'('h400 + $urandom % 'h400);
      access(1'($urandom % 2), 2'($urandom % 4), a, $urandom);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule